// File: doc/BRIEF.md
# Write-Path Fault Injector for Memory Bursts

This block sits in the write data path of a memory controller, ahead of the memory itself. On request it flips chosen bits in outgoing write data so that error-detection logic downstream can be tested. A cache line leaves the controller as a burst of four transfers. Each transfer is 144 bits wide and is made of eighteen byte-wide device lanes spread over two channels.

A single 32-bit control word says which of the four transfers are hit, which one or two device lanes are hit, and which byte pattern is XORed in on even and on odd transfers. It also holds the enable gating and an optional address-match qualifier. When the qualifier is on, only demand writes whose address the external comparator reports as matching are corrupted, and scrub and sparing writes always pass clean. Injection is armed by writing the control word with its enable bit set. A done pulse from the response logic disarms it, unless the control word tells the block to ignore that pulse.

Top module: `mem_err_inject`

## Requirements
- R1: After reset the control word reads 32'h1000_0000 (half-line field 2'b01, all else 0), inj_active is 0 and out_valid is 0.
- R2: A cycle with cfg_we high loads cfg_wdata into the control word, which appears on ctrl_q on the next cycle; the field layout is: bit 31 address-match enable, bit 30 done-ignore, bits 29:28 half-line select, bit 27 injection enable, bit 26 response-function select (driven on resp_func_sel), bits 25:10 XOR mask, bits 9:5 second lane pointer, bits 4:0 first lane pointer.
- R3: While injection is not armed, out_data equals wr_data whatever the other control fields hold.
- R4: The transfer index counts 0..3 over the valid beats of a burst. Half-line 2'b01 corrupts transfers 0 and 1, 2'b10 corrupts transfers 2 and 3, 2'b11 corrupts all four, and 2'b00 corrupts none.
- R5: Transfers 0 and 2 use mask bits 17:10 as their byte pattern, and transfers 1 and 3 use mask bits 25:18.
- R6: Lane k covers data bits 8k+7:8k. Each valid pointer's lane is XORed with the same byte pattern, and when both pointers name the same lane it is XORed only once.
- R7: A pointer value from 18 to 31 selects no lane.
- R8: With address matching enabled, only writes of kind 2'b00 (demand) with wr_addr_hit high are corrupted. Kinds 2'b01 (scrub), 2'b10 (sparing) and 2'b11 pass unchanged. With address matching disabled, every kind is corrupted.
- R9: A done_in pulse clears inj_active on the next cycle when bit 30 is 0. When bit 30 is 1 the pulse is ignored and injection stays armed. A control write in the same cycle takes priority.
- R10: out_valid and out_data follow wr_valid and the possibly corrupted wr_data with one cycle of latency. wr_sob forces the beat it comes with to transfer 0.
- R11: inj_active is set by a control write with bit 27 high and cleared by a control write with bit 27 low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write value |
| ctrl_q | output | 32 | Current control word |
| resp_func_sel | output | 1 | Response function selector (bit 26) |
| done_in | input | 1 | Done return from the response logic |
| inj_active | output | 1 | Injection armed |
| wr_valid | input | 1 | Write beat valid |
| wr_sob | input | 1 | First beat of a burst |
| wr_kind | input | 2 | 00 demand, 01 scrub, 10 sparing |
| wr_addr_hit | input | 1 | External address comparator hit |
| wr_data | input | 144 | Write beat data |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 144 | Possibly corrupted write data |
| out_corrupt | output | 1 | This output beat had injection applied |

## Verification
Each write beat's result is due one cycle after the beat is presented. The bench drives a beat on a falling edge and compares out_data at the next falling edge, after the single capturing rising edge. Control writes and done pulses take effect on the next rising edge, so ctrl_q and inj_active are sampled one falling edge after the strobe. The first beat after a reconfiguration then shows the new gating.

// File: rtl/err_inj_pkg.sv
package err_inj_pkg;
  localparam int LANES  = 18;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;
  localparam int BEATS  = 4;
  localparam int BEAT_W = $clog2(BEATS);
  localparam int PTR_W  = 5;

  typedef enum logic [1:0] {
    WK_DEMAND = 2'b00,
    WK_SCRUB  = 2'b01,
    WK_SPARE  = 2'b10,
    WK_OTHER  = 2'b11
  } wr_kind_e;

  typedef struct packed {
    logic             addr_en;
    logic             done_ign;
    logic [1:0]       half;
    logic             inj_en;
    logic             func;
    logic [15:0]      xmask;
    logic [PTR_W-1:0] ptr2;
    logic [PTR_W-1:0] ptr1;
  } inj_ctrl_t;

  localparam logic [31:0] CTRL_RST = 32'h1000_0000;

  // transfer lies in an enabled half of the line
  function automatic logic beat_in_half(input logic [1:0] half,
                                        input logic [BEAT_W-1:0] beat);
    return beat[BEAT_W-1] ? half[1] : half[0];
  endfunction

  // odd transfers take the upper mask byte
  function automatic logic [LANE_W-1:0] pick_byte(input logic [15:0] xmask,
                                                  input logic [BEAT_W-1:0] beat);
    return beat[0] ? xmask[15:8] : xmask[7:0];
  endfunction

  function automatic logic lane_hit(input logic [PTR_W-1:0] ptr, input int lane);
    return (int'(ptr) < LANES) && (int'(ptr) == lane);
  endfunction
endpackage

// File: rtl/err_inj_ctrl.sv
module err_inj_ctrl
  import err_inj_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_we,
  input  logic [31:0] cfg_wdata,
  input  logic      done_in,
  output inj_ctrl_t ctrl,
  output logic      armed
);
  logic done_clr;
  assign done_clr = done_in && !ctrl.done_ign;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl  <= inj_ctrl_t'(CTRL_RST);
      armed <= 1'b0;
    end else if (cfg_we) begin
      ctrl  <= inj_ctrl_t'(cfg_wdata);
      armed <= cfg_wdata[27];
    end else if (done_clr) begin
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/err_inj_beat.sv
module err_inj_beat #(
  parameter int BEATS  = 4,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_sob,
  output logic [BEAT_W-1:0] beat_idx
);
  logic [BEAT_W-1:0] cnt;

  assign beat_idx = wr_sob ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (wr_valid) cnt <= beat_idx + 1'b1;
  end
endmodule

// File: rtl/err_inj_lanes.sv
module err_inj_lanes
  import err_inj_pkg::*;
#(
  parameter int NLANES = LANES,
  parameter int LW     = LANE_W,
  localparam int DW    = NLANES * LW
) (
  input  logic             apply,
  input  logic [PTR_W-1:0] ptr1,
  input  logic [PTR_W-1:0] ptr2,
  input  logic [LW-1:0]    pattern,
  output logic [DW-1:0]    xor_vec
);
  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    logic sel;
    assign sel = apply && (lane_hit(ptr1, k) || lane_hit(ptr2, k));
    assign xor_vec[k*LW +: LW] = sel ? pattern : '0;
  end
endmodule

// File: rtl/mem_err_inject.sv
module mem_err_inject
  import err_inj_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       ctrl_q,
  output logic              resp_func_sel,
  input  logic              done_in,
  output logic              inj_active,
  input  logic              wr_valid,
  input  logic              wr_sob,
  input  logic [1:0]        wr_kind,
  input  logic              wr_addr_hit,
  input  logic [DATA_W-1:0] wr_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_corrupt
);
  inj_ctrl_t         ctrl;
  logic              armed;
  logic [BEAT_W-1:0] beat_idx;
  logic              beat_sel;
  logic              gate_ok;
  logic              do_inject;
  logic [LANE_W-1:0] pattern;
  logic [DATA_W-1:0] xor_vec;

  err_inj_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .done_in(done_in), .ctrl(ctrl), .armed(armed)
  );

  err_inj_beat #(.BEATS(BEATS)) u_beat (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sob(wr_sob),
    .beat_idx(beat_idx)
  );

  assign beat_sel  = beat_in_half(ctrl.half, beat_idx);
  assign gate_ok   = !ctrl.addr_en ||
                     ((wr_kind_e'(wr_kind) == WK_DEMAND) && wr_addr_hit);
  assign do_inject = wr_valid && armed && ctrl.inj_en && beat_sel && gate_ok;
  assign pattern   = pick_byte(ctrl.xmask, beat_idx);

  err_inj_lanes #(.NLANES(LANES), .LW(LANE_W)) u_lanes (
    .apply(do_inject), .ptr1(ctrl.ptr1), .ptr2(ctrl.ptr2),
    .pattern(pattern), .xor_vec(xor_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_corrupt <= 1'b0;
    end else begin
      out_valid   <= wr_valid;
      out_corrupt <= do_inject;
      if (wr_valid) out_data <= wr_data ^ xor_vec;
    end
  end

  assign ctrl_q        = ctrl;
  assign resp_func_sel = ctrl.func;
  assign inj_active    = armed;
endmodule

// File: rtl/err_inj_chk.sv
module err_inj_chk
  import err_inj_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [31:0]       cfg_wdata,
  input logic [31:0]       ctrl_q,
  input logic              done_in,
  input logic              inj_active,
  input logic              wr_valid,
  input logic [1:0]        wr_kind,
  input logic [DATA_W-1:0] wr_data,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_corrupt
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_ONE_CYCLE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> out_valid == $past(wr_valid)); // R10
  AST_CLEAN_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && out_valid && !$past(inj_active)) |-> out_data == $past(wr_data)); // R3
  AST_NONDEMAND_EXEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && out_valid && $past(ctrl_q[31]) && $past(wr_kind) != 2'b00)
      |-> out_data == $past(wr_data)); // R8
  AST_UNMARKED_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && out_valid && !out_corrupt) |-> out_data == $past(wr_data)); // R4
  AST_DONE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_active && done_in && !ctrl_q[30] && !cfg_we) |=> !inj_active); // R9
  AST_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_active && done_in && ctrl_q[30] && !cfg_we) |=> inj_active); // R9
  AST_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> inj_active == $past(cfg_wdata[27])); // R11
endmodule

bind mem_err_inject err_inj_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .ctrl_q(ctrl_q), .done_in(done_in), .inj_active(inj_active),
  .wr_valid(wr_valid), .wr_kind(wr_kind), .wr_data(wr_data),
  .out_valid(out_valid), .out_data(out_data), .out_corrupt(out_corrupt)
);

// File: tb/tb_mem_err_inject.sv
`timescale 1ns/1ps
module tb_mem_err_inject;
  localparam int DW = 144;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   ctrl_q;
  logic          resp_func_sel;
  logic          done_in = 1'b0;
  logic          inj_active;
  logic          wr_valid = 1'b0;
  logic          wr_sob = 1'b0;
  logic [1:0]    wr_kind = 2'b00;
  logic          wr_addr_hit = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          out_corrupt;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] m_ctrl;
  logic        m_armed;
  int          m_beat;

  always #2 clk = ~clk;

  mem_err_inject dut (.*);

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkctrl(input logic aen, input logic dign,
      input logic [1:0] half, input logic en, input logic fn,
      input logic [15:0] msk, input logic [4:0] p2, input logic [4:0] p1);
    return {aen, dign, half, en, fn, msk, p2, p1};
  endfunction

  function automatic logic [DW-1:0] mkdata(input int seed);
    logic [DW-1:0] d;
    for (int k = 0; k < 18; k++) d[8*k +: 8] = 8'(seed * 13 + k * 29 + 5);
    return d;
  endfunction

  // reference: restated from R3..R8
  function automatic logic [DW-1:0] expect_out(input int beat, input logic [1:0] kind,
      input logic hit, input logic [DW-1:0] d);
    logic [DW-1:0] r = d;
    logic [7:0] pat;
    logic lower_on, upper_on;
    int p1, p2;
    if (!m_armed || !m_ctrl[27]) return r;
    if (m_ctrl[31] && !(kind == 2'b00 && hit)) return r;
    lower_on = (m_ctrl[29:28] == 2'b01) || (m_ctrl[29:28] == 2'b11);
    upper_on = (m_ctrl[29:28] == 2'b10) || (m_ctrl[29:28] == 2'b11);
    if (beat < 2 ? !lower_on : !upper_on) return r;
    pat = (beat % 2 == 1) ? m_ctrl[25:18] : m_ctrl[17:10];
    p1 = int'(m_ctrl[4:0]);
    p2 = int'(m_ctrl[9:5]);
    for (int k = 0; k < 18; k++)
      if (k == p1 || k == p2) r[8*k +: 8] = r[8*k +: 8] ^ pat;
    return r;
  endfunction

  task automatic cfg_write(input logic [31:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    m_ctrl = v; m_armed = v[27];
  endtask

  task automatic beat(input string req, input logic sob, input logic [1:0] kind,
                      input logic hit, input logic [DW-1:0] d);
    logic [DW-1:0] e;
    int idx = sob ? 0 : m_beat;
    e = expect_out(idx, kind, hit, d);
    m_beat = (idx + 1) % 4;
    wr_valid = 1'b1; wr_sob = sob; wr_kind = kind; wr_addr_hit = hit; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; wr_sob = 1'b0;
    check({req, " out_valid"}, DW'(out_valid), DW'(1'b1));
    check(req, out_data, e);
  endtask

  task automatic burst(input string req, input int seed);
    for (int b = 0; b < 4; b++) beat(req, b == 0, 2'b00, 1'b0, mkdata(seed + b));
  endtask

  task automatic t_reset;
    check("R1 ctrl", DW'(ctrl_q), DW'(32'h1000_0000));
    check("R1 inj_active", DW'(inj_active), '0);
    check("R1 out_valid", DW'(out_valid), '0);
  endtask

  task automatic t_cfg;
    cfg_write(32'hA5C3_1E2B);
    check("R2 readback", DW'(ctrl_q), DW'(32'hA5C3_1E2B));
    check("R2 func", DW'(resp_func_sel), DW'(1'b1));
    cfg_write(32'h0000_0000);
    check("R2 func0", DW'(resp_func_sel), '0);
  endtask

  task automatic t_disabled;
    cfg_write(mkctrl(1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 16'hFFFF, 5'd3, 5'd4));
    burst("R3 disabled", 10);
    check("R3 idle", DW'(inj_active), '0);
  endtask

  task automatic t_arm;
    cfg_write(mkctrl(1'b0, 1'b0, 2'b01, 1'b1, 1'b0, 16'h0101, 5'd1, 5'd0));
    check("R11 armed", DW'(inj_active), DW'(1'b1));
    cfg_write(mkctrl(1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 16'h0101, 5'd1, 5'd0));
    check("R11 disarmed", DW'(inj_active), '0);
  endtask

  task automatic t_half;
    for (int h = 0; h < 4; h++) begin
      cfg_write(mkctrl(1'b0, 1'b0, 2'(h), 1'b1, 1'b0, 16'h3C81, 5'd9, 5'd2));
      burst("R4 half select", 20 + h);
    end
  endtask

  task automatic t_masks;
    cfg_write(mkctrl(1'b0, 1'b0, 2'b11, 1'b1, 1'b0, 16'hF00F, 5'd17, 5'd0));
    burst("R5 mask bytes", 40);
    burst("R6 two lanes", 44);
    cfg_write(mkctrl(1'b0, 1'b0, 2'b11, 1'b1, 1'b0, 16'h5AA5, 5'd7, 5'd7));
    burst("R6 same lane once", 48);
  endtask

  task automatic t_ptr_range;
    cfg_write(mkctrl(1'b0, 1'b0, 2'b11, 1'b1, 1'b0, 16'hFFFF, 5'd31, 5'd18));
    burst("R7 no lane", 52);
    cfg_write(mkctrl(1'b0, 1'b0, 2'b11, 1'b1, 1'b0, 16'hFFFF, 5'd20, 5'd5));
    burst("R7 one valid", 56);
  endtask

  task automatic t_addr;
    cfg_write(mkctrl(1'b1, 1'b0, 2'b11, 1'b1, 1'b0, 16'h8421, 5'd11, 5'd6));
    beat("R8 demand hit", 1'b1, 2'b00, 1'b1, mkdata(60));
    beat("R8 demand miss", 1'b0, 2'b00, 1'b0, mkdata(61));
    beat("R8 scrub hit", 1'b0, 2'b01, 1'b1, mkdata(62));
    beat("R8 sparing hit", 1'b0, 2'b10, 1'b1, mkdata(63));
    beat("R8 kind3 hit", 1'b1, 2'b11, 1'b1, mkdata(64));
    cfg_write(mkctrl(1'b0, 1'b0, 2'b11, 1'b1, 1'b0, 16'h8421, 5'd11, 5'd6));
    beat("R8 scrub no match mode", 1'b1, 2'b01, 1'b0, mkdata(65));
  endtask

  task automatic t_done;
    cfg_write(mkctrl(1'b0, 1'b0, 2'b11, 1'b1, 1'b0, 16'h1234, 5'd2, 5'd1));
    done_in = 1'b1; @(negedge clk); done_in = 1'b0;
    if (!m_ctrl[30]) m_armed = 1'b0;
    check("R9 done clears", DW'(inj_active), '0);
    burst("R9 after clear", 70);
    cfg_write(mkctrl(1'b0, 1'b1, 2'b11, 1'b1, 1'b0, 16'h1234, 5'd2, 5'd1));
    done_in = 1'b1; @(negedge clk); done_in = 1'b0;
    check("R9 done ignored", DW'(inj_active), DW'(1'b1));
    burst("R9 still armed", 74);
  endtask

  task automatic t_sob;
    cfg_write(mkctrl(1'b0, 1'b0, 2'b10, 1'b1, 1'b0, 16'hC318, 5'd14, 5'd8));
    beat("R10 sob", 1'b1, 2'b00, 1'b0, mkdata(80));
    beat("R10 beat1", 1'b0, 2'b00, 1'b0, mkdata(81));
    beat("R10 restart", 1'b1, 2'b00, 1'b0, mkdata(82));
    @(negedge clk);
    check("R10 gap idle", DW'(out_valid), '0);
    beat("R10 beat1b", 1'b0, 2'b00, 1'b0, mkdata(83));
    beat("R10 beat2", 1'b0, 2'b00, 1'b0, mkdata(84));
    beat("R10 beat3", 1'b0, 2'b00, 1'b0, mkdata(85));
  endtask

  initial begin
    m_ctrl = 32'h1000_0000; m_armed = 1'b0; m_beat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_disabled();
    t_arm();
    t_half();
    t_masks();
    t_ptr_range();
    t_addr();
    t_done();
    t_sob();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule